// File: doc/BRIEF.md
# Command-Phase Register Access Interpreter

This block is the slave side of a 16-bit parallel microprocessor bus in a USB device controller. Each bus cycle carries a select bit. With the select bit high, the cycle is a command: the low byte of the bus is an opcode. With it low, the cycle is a data transfer to or from the register that the last opcode named. The block decodes opcodes into targets and holds those registers. The targets are a bank of sixteen endpoint configuration words, the device address, the mode, the hardware configuration, the two-word interrupt enable, the DMA configuration and the DMA counter. One opcode clears every register and has no data phase.

A word counter steps through multi-word registers, least significant word first, and restarts on every command. Data cycles beyond the last word of a register, and data cycles under an opcode the block does not recognise, are ignored. Reads in those cycles return zero. Read data is combinational from the current opcode and word counter, so the host samples it during the read cycle.

Top module: `cmdRegInterp`

## Requirements
- R1: After reset every register reads as zero, and a data read issued before any command returns 0x0000.
- R2: A command cycle (busSel=1, busWr=1) takes only busWrData[7:0] as the opcode, and bits 15:8 have no effect on decoding.
- R3: Opcode 0x20+n writes endpoint configuration word n (n=0..15, with 0 for control OUT and 1 for control IN), and opcode 0x30+n reads it back. Each is a one-word transfer that leaves the other words unchanged.
- R4: Even opcodes write and odd opcodes read one word: 0xB6/0xB7 device address, 0xB8/0xB9 mode, 0xBA/0xBB hardware configuration, 0xF0/0xF1 DMA configuration, 0xF2/0xF3 DMA counter.
- R5: Opcodes 0xC2/0xC3 write/read the 32-bit interrupt enable as two data cycles, bits 15:0 first and bits 31:16 second.
- R6: The word counter restarts at zero on every command cycle. A data write after a register's last word changes nothing, and a data read there returns 0x0000.
- R7: After an unrecognised opcode, data writes change no register and data reads return 0x0000.
- R8: Opcode 0xF6 clears every register in the command cycle itself and opens no data phase, so a following data write changes nothing.
- R9: A synchronous active-high rst clears every register and the current opcode at the next clock edge.
- R10: A data write under a read opcode changes nothing, and a data read under a write opcode returns 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busSel | input | 1 | 1 = command cycle, 0 = data cycle |
| busWr | input | 1 | Write strobe for the current cycle |
| busRd | input | 1 | Read strobe for a data cycle |
| busWrData | input | 16 | Write data or opcode (low byte) |
| busRdData | output | 16 | Read data of the current data cycle |

## Verification
On every cycle, assertions check the following: the word counter restarts after each command and never passes the target's word count; a known opcode lands on its target whatever the high byte holds; registers stay stable in any cycle without an accepted write; and the clear opcode and the reset input leave all registers at zero. Assertions also check that read data is zero whenever no readable word is selected. Only the bench scenarios can show that each opcode reaches the right register and word. They also show the least-significant-first order of the interrupt enable, that values survive across unrelated accesses, and that writes under read opcodes, unknown opcodes or past the last word leave the stored values as they were.

// File: rtl/hostCmdPkg.sv
package hostCmdPkg;
  localparam int WORD_W    = 16;
  localparam int CODE_W    = 8;
  localparam int EP_COUNT  = 16;
  localparam int EP_IDX_W  = $clog2(EP_COUNT);
  localparam int INT_WORDS = 2;
  localparam int IDX_W     = (INT_WORDS > 1) ? $clog2(INT_WORDS) : 1;
  localparam int WCNT_W    = $clog2(INT_WORDS + 1);

  localparam logic [CODE_W-1:0] OP_CLEAR_ALL = 8'hF6;

  typedef enum logic [2:0] {
    TGT_NONE, TGT_EPCFG, TGT_DEVADDR, TGT_MODE,
    TGT_HWCFG, TGT_INTEN, TGT_DMACFG, TGT_DMACNT
  } tgt_e;

  typedef struct packed {
    tgt_e                tgt;
    logic                isWrite;
    logic [EP_IDX_W-1:0] epIdx;
    logic [WCNT_W-1:0]   words;
  } cmdInfo_t;

  typedef struct packed {
    logic                wrStb;
    logic                rdSel;
    logic                clearAll;
    tgt_e                tgt;
    logic [EP_IDX_W-1:0] epIdx;
    logic [IDX_W-1:0]    wordIdx;
  } ctrlStb_t;

  function automatic cmdInfo_t decodeCmd(input logic [CODE_W-1:0] code);
    cmdInfo_t info;
    info = '0;
    info.tgt = TGT_NONE;
    if (code[7:5] == 3'b001) begin
      info.tgt     = TGT_EPCFG;
      info.isWrite = ~code[4];
      info.epIdx   = code[EP_IDX_W-1:0];
    end else begin
      info.isWrite = ~code[0];
      case (code[7:1])
        7'h5B:   info.tgt = TGT_DEVADDR;
        7'h5C:   info.tgt = TGT_MODE;
        7'h5D:   info.tgt = TGT_HWCFG;
        7'h61:   info.tgt = TGT_INTEN;
        7'h78:   info.tgt = TGT_DMACFG;
        7'h79:   info.tgt = TGT_DMACNT;
        default: info.tgt = TGT_NONE;
      endcase
    end
    if (info.tgt == TGT_INTEN)     info.words = WCNT_W'(INT_WORDS);
    else if (info.tgt != TGT_NONE) info.words = WCNT_W'(1);
    else                           info.words = '0;
    return info;
  endfunction
endpackage

// File: rtl/cmdRegCtrl.sv
module cmdRegCtrl
  import hostCmdPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              busSel,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [CODE_W-1:0] cmdByte,
  output ctrlStb_t          stb
);
  cmdInfo_t          curCmd;
  logic [WCNT_W-1:0] wordCnt;
  logic              cmdStrobe, dataWr, dataRd, inRange;

  assign cmdStrobe = busSel & busWr;
  assign dataWr    = ~busSel & busWr;
  assign dataRd    = ~busSel & busRd & ~busWr;
  assign inRange   = (wordCnt < curCmd.words);

  always_ff @(posedge clk) begin
    if (rst) begin
      curCmd     <= '0;
      curCmd.tgt <= TGT_NONE;
      wordCnt    <= '0;
    end else if (cmdStrobe) begin
      curCmd  <= decodeCmd(cmdByte);
      wordCnt <= '0;
    end else if ((dataWr || dataRd) && inRange) begin
      wordCnt <= wordCnt + 1'b1;
    end
  end

  always_comb begin
    stb          = '0;
    stb.tgt      = curCmd.tgt;
    stb.epIdx    = curCmd.epIdx;
    stb.wordIdx  = wordCnt[IDX_W-1:0];
    stb.wrStb    = dataWr & curCmd.isWrite & inRange;
    stb.rdSel    = ~curCmd.isWrite & inRange;
    stb.clearAll = cmdStrobe & (cmdByte == OP_CLEAR_ALL);
  end

  // R6: counter restarts on every command cycle
  assert_cnt_restart_R6: assert property (@(posedge clk) disable iff (rst)
    cmdStrobe |=> (wordCnt == '0));

  // R6: counter never passes the word count of its target
  assert_cnt_bounded_R6: assert property (@(posedge clk) disable iff (rst)
    wordCnt <= curCmd.words);

  // R2: high byte cannot disturb decoding of a known opcode
  assert_low_byte_only_R2: assert property (@(posedge clk) disable iff (rst)
    (cmdStrobe && cmdByte == 8'hB6) |=> (curCmd.tgt == TGT_DEVADDR && curCmd.isWrite));

  // R8: the clear opcode opens no data phase
  assert_clear_no_target_R8: assert property (@(posedge clk) disable iff (rst)
    (cmdStrobe && cmdByte == OP_CLEAR_ALL) |=> (curCmd.tgt == TGT_NONE));
endmodule

// File: rtl/cmdRegData.sv
module cmdRegData
  import hostCmdPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  ctrlStb_t          stb,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdWord
);
  logic [EP_COUNT-1:0][WORD_W-1:0]  epCfg;
  logic [INT_WORDS-1:0][WORD_W-1:0] intEn;
  logic [WORD_W-1:0] devAddr, modeReg, hwCfg, dmaCfg, dmaCnt;

  always_ff @(posedge clk) begin
    if (rst || stb.clearAll) begin
      epCfg   <= '0;
      intEn   <= '0;
      devAddr <= '0;
      modeReg <= '0;
      hwCfg   <= '0;
      dmaCfg  <= '0;
      dmaCnt  <= '0;
    end else if (stb.wrStb) begin
      case (stb.tgt)
        TGT_EPCFG:   epCfg[stb.epIdx]   <= wrData;
        TGT_DEVADDR: devAddr            <= wrData;
        TGT_MODE:    modeReg            <= wrData;
        TGT_HWCFG:   hwCfg              <= wrData;
        TGT_INTEN:   intEn[stb.wordIdx] <= wrData;
        TGT_DMACFG:  dmaCfg             <= wrData;
        TGT_DMACNT:  dmaCnt             <= wrData;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdWord = '0;
    if (stb.rdSel) begin
      case (stb.tgt)
        TGT_EPCFG:   rdWord = epCfg[stb.epIdx];
        TGT_DEVADDR: rdWord = devAddr;
        TGT_MODE:    rdWord = modeReg;
        TGT_HWCFG:   rdWord = hwCfg;
        TGT_INTEN:   rdWord = intEn[stb.wordIdx];
        TGT_DMACFG:  rdWord = dmaCfg;
        TGT_DMACNT:  rdWord = dmaCnt;
        default:     rdWord = '0;
      endcase
    end
  end

  // R7 / R10: without an accepted write or clear, no register moves
  assert_hold_without_write_R10: assert property (@(posedge clk) disable iff (rst)
    (!stb.wrStb && !stb.clearAll) |=> ($stable(epCfg) && $stable(intEn) && $stable(devAddr)
      && $stable(modeReg) && $stable(hwCfg) && $stable(dmaCfg) && $stable(dmaCnt)));

  // R8: clear opcode zeroes the whole register file
  assert_clear_all_R8: assert property (@(posedge clk) disable iff (rst)
    stb.clearAll |=> (epCfg == '0 && intEn == '0 && devAddr == '0 && modeReg == '0
      && hwCfg == '0 && dmaCfg == '0 && dmaCnt == '0));

  // R9: reset input zeroes the whole register file
  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> (epCfg == '0 && intEn == '0 && devAddr == '0 && modeReg == '0
      && hwCfg == '0 && dmaCfg == '0 && dmaCnt == '0));

  // R6 / R7: nothing readable selected means zero on the bus
  assert_idle_read_zero_R7: assert property (@(posedge clk) disable iff (rst)
    !stb.rdSel |-> (rdWord == '0));
endmodule

// File: rtl/cmdRegInterp.sv
module cmdRegInterp
  import hostCmdPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              busSel,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [WORD_W-1:0] busWrData,
  output logic [WORD_W-1:0] busRdData
);
  ctrlStb_t stb;

  cmdRegCtrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .busSel  (busSel),
    .busWr   (busWr),
    .busRd   (busRd),
    .cmdByte (busWrData[CODE_W-1:0]),
    .stb     (stb)
  );

  cmdRegData u_data (
    .clk    (clk),
    .rst    (rst),
    .stb    (stb),
    .wrData (busWrData),
    .rdWord (busRdData)
  );
endmodule

// File: tb/cmdRegInterp_bench.sv
`timescale 1ns/1ps
module cmdRegInterp_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic busSel = 1'b0, busWr = 1'b0, busRd = 1'b0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  cmdRegInterp u_cmdRegInterp (
    .clk(clk), .rst(rst), .busSel(busSel), .busWr(busWr),
    .busRd(busRd), .busWrData(busWrData), .busRdData(busRdData)
  );

  localparam logic [1:0] K_CMD = 2'd0, K_WR = 2'd1, K_RD = 2'd2;
  localparam int VEC_N = 55;
  // {kind, data, expected read, requirement number}
  localparam logic [37:0] VECS [VEC_N] = '{
    {K_CMD, 16'h0020, 16'h0000, 4'd3},   // R3 write control OUT cfg
    {K_WR,  16'h1234, 16'h0000, 4'd3},
    {K_CMD, 16'h0030, 16'h0000, 4'd3},
    {K_RD,  16'h0000, 16'h1234, 4'd3},
    {K_CMD, 16'h002F, 16'h0000, 4'd3},   // R3 last endpoint
    {K_WR,  16'hBEEF, 16'h0000, 4'd3},
    {K_CMD, 16'h003F, 16'h0000, 4'd3},
    {K_RD,  16'h0000, 16'hBEEF, 4'd3},
    {K_CMD, 16'h0030, 16'h0000, 4'd3},
    {K_RD,  16'h0000, 16'h1234, 4'd3},   // R3 neighbour untouched
    {K_CMD, 16'h00B6, 16'h0000, 4'd4},   // R4 write pairs
    {K_WR,  16'h0055, 16'h0000, 4'd4},
    {K_CMD, 16'h00B8, 16'h0000, 4'd4},
    {K_WR,  16'h00A5, 16'h0000, 4'd4},
    {K_CMD, 16'h00BA, 16'h0000, 4'd4},
    {K_WR,  16'h3C3C, 16'h0000, 4'd4},
    {K_CMD, 16'h00F0, 16'h0000, 4'd4},
    {K_WR,  16'h0F0F, 16'h0000, 4'd4},
    {K_CMD, 16'h00F2, 16'h0000, 4'd4},
    {K_WR,  16'hFFFF, 16'h0000, 4'd4},
    {K_CMD, 16'h00B7, 16'h0000, 4'd4},
    {K_RD,  16'h0000, 16'h0055, 4'd4},
    {K_CMD, 16'h00B9, 16'h0000, 4'd4},
    {K_RD,  16'h0000, 16'h00A5, 4'd4},
    {K_CMD, 16'h00BB, 16'h0000, 4'd4},
    {K_RD,  16'h0000, 16'h3C3C, 4'd4},
    {K_CMD, 16'h00F1, 16'h0000, 4'd4},
    {K_RD,  16'h0000, 16'h0F0F, 4'd4},
    {K_CMD, 16'h00F3, 16'h0000, 4'd4},
    {K_RD,  16'h0000, 16'hFFFF, 4'd4},
    {K_CMD, 16'h00C2, 16'h0000, 4'd5},   // R5 two-word register
    {K_WR,  16'h1111, 16'h0000, 4'd5},
    {K_WR,  16'h2222, 16'h0000, 4'd5},
    {K_WR,  16'h3333, 16'h0000, 4'd6},   // R6 extra word ignored
    {K_CMD, 16'h00C3, 16'h0000, 4'd5},
    {K_RD,  16'h0000, 16'h1111, 4'd5},
    {K_RD,  16'h0000, 16'h2222, 4'd5},
    {K_RD,  16'h0000, 16'h0000, 4'd6},   // R6 read past last word
    {K_CMD, 16'hAB21, 16'h0000, 4'd2},   // R2 junk high byte
    {K_WR,  16'h7777, 16'h0000, 4'd2},
    {K_CMD, 16'h5531, 16'h0000, 4'd2},
    {K_RD,  16'h0000, 16'h7777, 4'd2},
    {K_CMD, 16'h0050, 16'h0000, 4'd7},   // R7 unknown opcode
    {K_WR,  16'h9999, 16'h0000, 4'd7},
    {K_RD,  16'h0000, 16'h0000, 4'd7},
    {K_CMD, 16'h00B7, 16'h0000, 4'd7},
    {K_RD,  16'h0000, 16'h0055, 4'd7},
    {K_CMD, 16'h00B7, 16'h0000, 4'd10},  // R10 write under read opcode
    {K_WR,  16'hDEAD, 16'h0000, 4'd10},
    {K_CMD, 16'h00B7, 16'h0000, 4'd10},
    {K_RD,  16'h0000, 16'h0055, 4'd10},
    {K_CMD, 16'h00B6, 16'h0000, 4'd10},
    {K_RD,  16'h0000, 16'h0000, 4'd10},  // R10 read under write opcode
    {K_CMD, 16'h00C3, 16'h0000, 4'd6},   // R6 counter restarted
    {K_RD,  16'h0000, 16'h1111, 4'd6}
  };

  task automatic busOp(input logic [1:0] kind, input logic [15:0] data);
    @(negedge clk);
    busSel    = (kind == K_CMD);
    busWr     = (kind != K_RD);
    busRd     = (kind == K_RD);
    busWrData = data;
    #1;
  endtask

  task automatic checkRd(input logic [15:0] exp, input int req);
    checks++;
    if (busRdData !== exp) begin
      errors++;
      $display("FAIL R%0d: busRdData got %h expected %h", req, busRdData, exp);
    end
  endtask

  task automatic rdCheck(input logic [15:0] exp, input int req);
    busOp(K_RD, 16'h0000);
    checkRd(exp, req);
  endtask

  task automatic idle();
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; busRd = 1'b0; busWrData = '0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    rdCheck(16'h0000, 1);
    busOp(K_CMD, 16'h00B7); rdCheck(16'h0000, 1);
    busOp(K_CMD, 16'h00C3); rdCheck(16'h0000, 1); rdCheck(16'h0000, 1);
    busOp(K_CMD, 16'h003F); rdCheck(16'h0000, 1);

    for (int i = 0; i < VEC_N; i++) begin
      busOp(VECS[i][37:36], VECS[i][35:20]);
      if (VECS[i][37:36] == K_RD) checkRd(VECS[i][19:4], int'(VECS[i][3:0]));
    end

    // R8 clear opcode, then a data write that must land nowhere
    busOp(K_CMD, 16'h00F6);
    busOp(K_WR, 16'h1234);
    busOp(K_CMD, 16'h00B7); rdCheck(16'h0000, 8);
    busOp(K_CMD, 16'h00C3); rdCheck(16'h0000, 8); rdCheck(16'h0000, 8);
    busOp(K_CMD, 16'h003F); rdCheck(16'h0000, 8);
    busOp(K_CMD, 16'h0030); rdCheck(16'h0000, 8);
    busOp(K_CMD, 16'h00F3); rdCheck(16'h0000, 8);

    // R9 reset input
    busOp(K_CMD, 16'h00B6); busOp(K_WR, 16'h00AA);
    busOp(K_CMD, 16'h00B7); rdCheck(16'h00AA, 9);
    idle();
    rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    rdCheck(16'h0000, 9);
    busOp(K_CMD, 16'h00B7); rdCheck(16'h0000, 9);
    idle();

    repeat (2) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule